// File: doc/BRIEF.md
# Accumulator Fetch-Execute Controller

This block is a multi-cycle controller for a machine with one accumulator. Program and operands share a single read/write word memory that the block reaches through one address bus with separate read and write strobes. Each instruction is carried out as a chain of single register transfers. The program counter feeds the address register. The fetched word lands in the buffer register and then moves to the instruction register. The instruction's address field is then copied into the address register for the operand access.

Three operations are supported, each taking a direct memory address: load into the accumulator, store from the accumulator, and add to the accumulator. Any other opcode stops the machine. The memory is external, synchronous and has a fixed latency of one cycle, so the port has no back-pressure. A read strobe always returns its word on the next cycle, and a write strobe always commits at that clock edge. The program counter and accumulator are brought out as plain status outputs, together with a halt flag.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `pc_o` = 0, `acc_o` = 0, `halted` = 0, and neither `mem_rd` nor `mem_wr` is high.
- R2: An instruction word carries its opcode in bits [15:12] (1 = load, 2 = store, 3 = add) and its operand address in the low `ADDR_W` bits. Any bits in between are ignored. Code and data live in the same memory, so a word that was stored can later be fetched as an instruction.
- R3: Each fetch raises `mem_rd` with `mem_addr` equal to the program counter, one cycle after the instruction starts. The word is taken from `mem_rdata` on the following cycle.
- R4: A load places the memory word at the operand address into the accumulator.
- R5: A store writes the accumulator to the operand address. `mem_wdata` equals `acc_o` while `mem_wr` is high, and the accumulator is left unchanged.
- R6: An add replaces the accumulator with accumulator plus operand, modulo 2^16.
- R7: After every completed instruction the program counter increases by exactly one, wrapping modulo 2^`ADDR_W`. It never changes in any other way.
- R8: Opcode 0 or 4 through 15 (15 is the intended halt) raises `halted`. The flag stays high until reset. The program counter keeps the address of the stopping word, and no further strobe is issued.
- R9: A load or an add takes 9 cycles and a store takes 8 cycles. `halted` rises 5 cycles after the stopping word's fetch sequence begins.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W | Word address for the current access |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe; `mem_wdata` commits at this edge |
| mem_wdata | output | DATA_W | Word to be written |
| mem_rdata | input | DATA_W | Word returned one cycle after a read strobe |
| halted | output | 1 | Machine has stopped on a non-executable opcode |
| pc_o | output | ADDR_W | Current program counter |
| acc_o | output | DATA_W | Current accumulator |

## Verification
The bench builds the block with `ADDR_W` = 8, which gives a 256-word memory. At that size a straight-line program can run past the top address and wrap the program counter back to zero. The same run also stores into its own first code word and then fetches it back. Random programs place their operands in the upper half of memory and fill the ignored middle bits of each instruction with random values. The add overflow case uses full 16-bit operands.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'h3;

  typedef enum logic [3:0] {
    S_FETCH_MAR,
    S_FETCH_RD,
    S_FETCH_MBR,
    S_FETCH_IR,
    S_DECODE,
    S_OP_RD,
    S_OP_MBR,
    S_EXEC,
    S_ST_MBR,
    S_ST_WR,
    S_INC,
    S_HALT
  } cpu_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic ir_from_mbr;
    logic acc_from_mbr;
    logic acc_from_sum;
    logic pc_step;
  } xfer_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD);
  endfunction
endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output xfer_t           xfer,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            halted
);
  cpu_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_FETCH_MAR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH_MAR: state_d = S_FETCH_RD;
      S_FETCH_RD:  state_d = S_FETCH_MBR;
      S_FETCH_MBR: state_d = S_FETCH_IR;
      S_FETCH_IR:  state_d = S_DECODE;
      S_DECODE: begin
        if (!op_known(opcode))       state_d = S_HALT;
        else if (opcode == OPC_STORE) state_d = S_ST_MBR;
        else                          state_d = S_OP_RD;
      end
      S_OP_RD:  state_d = S_OP_MBR;
      S_OP_MBR: state_d = S_EXEC;
      S_EXEC:   state_d = S_INC;
      S_ST_MBR: state_d = S_ST_WR;
      S_ST_WR:  state_d = S_INC;
      S_INC:    state_d = S_FETCH_MAR;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_HALT;
    endcase
  end

  always_comb begin
    xfer = '0;
    unique case (state_q)
      S_FETCH_MAR: xfer.mar_from_pc  = 1'b1;
      S_FETCH_MBR: xfer.mbr_from_mem = 1'b1;
      S_FETCH_IR:  xfer.ir_from_mbr  = 1'b1;
      S_DECODE:    xfer.mar_from_ir  = op_known(opcode);
      S_OP_MBR:    xfer.mbr_from_mem = 1'b1;
      S_EXEC: begin
        xfer.acc_from_mbr = (opcode == OPC_LOAD);
        xfer.acc_from_sum = (opcode == OPC_ADD);
      end
      S_ST_MBR:    xfer.mbr_from_acc = 1'b1;
      S_INC:       xfer.pc_step      = 1'b1;
      default:     xfer = '0;
    endcase
  end

  assign mem_rd = (state_q == S_FETCH_RD) || (state_q == S_OP_RD);
  assign mem_wr = (state_q == S_ST_WR);
  assign halted = (state_q == S_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT) |=> (state_q == S_HALT)); // R8

  AST_FETCH_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_INC) |=> (state_q == S_FETCH_MAR) ##1 mem_rd); // R3

  AST_ONE_TRANSFER_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer.acc_from_mbr && xfer.acc_from_sum)); // R4
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [OP_W-1:0]   ir_op
);
  localparam int OP_LSB = DATA_W - OP_W;

  logic [ADDR_W-1:0] ir_adr;
  logic [DATA_W-1:0] sum;

  acc_adder #(.W(DATA_W)) u_add (.a(acc), .b(mbr), .sum(sum));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      mar    <= '0;
      mbr    <= '0;
      acc    <= '0;
      ir_op  <= '0;
      ir_adr <= '0;
    end else begin
      if (xfer.mar_from_pc)       mar <= pc;
      else if (xfer.mar_from_ir)  mar <= ir_adr;
      if (xfer.mbr_from_mem)      mbr <= mem_rdata;
      else if (xfer.mbr_from_acc) mbr <= acc;
      if (xfer.ir_from_mbr) begin
        ir_op  <= mbr[DATA_W-1 -: OP_W];
        ir_adr <= mbr[ADDR_W-1:0];
      end
      if (xfer.acc_from_mbr)      acc <= mbr;
      else if (xfer.acc_from_sum) acc <= sum;
      if (xfer.pc_step)           pc <= pc + 1'b1;
    end
  end

  AST_PC_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1)); // R7

  AST_MAR_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer.mar_from_pc && xfer.mar_from_ir)); // R3

  if (ADDR_W > OP_LSB) begin : g_bad_width
    initial assert (0) else $error("address field overlaps opcode");
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  xfer_t             xfer;
  logic [OP_W-1:0]   ir_op;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;

  acc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_op),
    .xfer   (xfer),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .mar       (mar),
    .mbr       (mbr),
    .pc        (pc_o),
    .acc       (acc_o),
    .ir_op     (ir_op)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == acc_o)); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr)); // R8

  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc_o)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!mem_rd && !mem_wr && !halted)); // R1
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] acc_o;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] em  [DEPTH];
  int n_chk = 0, n_bad = 0;
  int halt_strobes = 0;

  always #4 clk = ~clk;

  acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .pc_o(pc_o), .acc_o(acc_o)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk)
    if (rst_n && halted && (mem_rd || mem_wr)) halt_strobes++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_prog(input string name);
    logic [DW-1:0] eacc;
    logic [AW-1:0] epc;
    int ecyc, cyc, steps;
    bit stop;
    logic [3:0] op;
    logic [AW-1:0] a;
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) em[i] = mem[i];
    eacc = '0; epc = '0; ecyc = 0; steps = 0; stop = 1'b0;
    while (!stop && steps < 5000) begin
      op = em[epc][15:12];
      a  = em[epc][AW-1:0];
      case (op)
        4'h1: begin eacc = em[a]; ecyc += 9; epc = epc + 1'b1; end
        4'h2: begin em[a] = eacc; ecyc += 8; epc = epc + 1'b1; end
        4'h3: begin eacc = eacc + em[a]; ecyc += 9; epc = epc + 1'b1; end
        default: begin ecyc += 5; stop = 1'b1; end
      endcase
      steps++;
    end
    repeat (2) @(negedge clk);
    chk(pc_o == 0 && acc_o == 0 && !halted && !mem_rd && !mem_wr, "R1",
        {name, " reset state"}, {pc_o, acc_o}, 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 30000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc == 1)
        chk(mem_rd && mem_addr == 0, "R3", {name, " first fetch strobe"},
            {mem_rd, mem_addr}, {1'b1, 8'h00});
    end
    chk(halted, "R8", {name, " watchdog/halt reached"}, halted, 1);
    chk(cyc == ecyc, "R9", {name, " cycles to halt"}, cyc, ecyc);
    chk(acc_o == eacc, "R4", {name, " accumulator (R5 R6)"}, acc_o, eacc);
    chk(pc_o == epc, "R7", {name, " program counter"}, pc_o, epc);
    begin
      int bad_at;
      bad_at = -1;
      for (int i = 0; i < DEPTH; i++)
        if (bad_at < 0 && mem[i] !== em[i]) bad_at = i;
      chk(bad_at < 0, "R5", {name, " memory image (R2)"}, bad_at,
          (bad_at < 0) ? 0 : em[bad_at]);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // halt on an all-zero memory: opcode 0 stops at pc 0 after 5 cycles
    clear_mem();
    run_prog("zero-mem halt R8");

    // add overflow wraps modulo 2^16, store of the result
    clear_mem();
    mem[0] = 16'h1080; mem[1] = 16'h3081; mem[2] = 16'h2082; mem[3] = 16'hF000;
    mem[8'h80] = 16'hFFFF; mem[8'h81] = 16'h0002;
    run_prog("add overflow R6");
    chk(acc_o == 16'h0001, "R6", "wrapped sum", acc_o, 1);
    chk(mem[8'h82] == 16'h0001, "R5", "stored sum", mem[8'h82], 1);

    // halted stays put: no strobes, pc stable
    begin
      logic [AW-1:0] pc_seen;
      pc_seen = pc_o;
      halt_strobes = 0;
      repeat (20) @(negedge clk);
      chk(halted && pc_o == pc_seen && halt_strobes == 0, "R8",
          "sticky halt", {halt_strobes[7:0], pc_o}, {8'h00, pc_seen});
    end

    // unknown opcode 7 with junk middle bits halts; middle bits ignored on load
    clear_mem();
    mem[0] = 16'h1A90; mem[1] = 16'h7123; mem[8'h90] = 16'h5A5A;
    run_prog("opcode 7 R2");
    chk(acc_o == 16'h5A5A && pc_o == 1, "R2", "load then stop",
        {acc_o, pc_o}, {16'h5A5A, 8'h01});

    // pc wraps past the top; a stored word becomes the stopping instruction
    clear_mem();
    for (int i = 0; i < 254; i++) mem[i] = 16'h1005;
    mem[254] = 16'h30FE;
    mem[255] = 16'h2000;
    run_prog("pc wrap self-modify R7");
    chk(pc_o == 0 && mem[0] == 16'h4103, "R7", "wrap to 0, fetched stored word",
        {pc_o, mem[0]}, {8'h00, 16'h4103});

    // constrained random programs
    for (int p = 0; p < 24; p++) begin
      int n;
      clear_mem();
      n = 1 + int'($urandom % 30);
      for (int i = 0; i < n; i++) begin
        logic [3:0] op;
        logic [3:0] mid;
        logic [AW-1:0] a;
        op  = 4'(1 + $urandom % 3);
        mid = 4'($urandom);
        a   = AW'(128 + $urandom % 128);
        mem[i] = {op, mid, a};
      end
      mem[n] = ($urandom % 2) ? 16'hF000 : {4'(4 + $urandom % 11), 12'($urandom)};
      for (int i = 128; i < DEPTH; i++) mem[i] = 16'($urandom);
      run_prog($sformatf("random %0d", p));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected halt");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule